// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. It holds a down-counter that reloads from a programmable load value. When enabled, it counts one step per clock. The first time the count runs out, it raises an interrupt and starts counting again from the load value. If that interrupt has still not been serviced when the count runs out a second time, and the reset stage is enabled, it drives a system reset request. That request stays high until the block itself is reset.

Software keeps the system alive by writing the interrupt-clear register often enough. That write clears the pending interrupt and reloads the counter. A write-protection gate guards every register except the gate itself. Writes are ignored until a 32-bit key has been written to the gate. Writing any other value to the gate closes it again.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where it is presented. Read data is registered and appears after that edge.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the gate is open (gate register reads 0), the load register reads 0xFFFFFFFF, the control register reads 0, the counter reads 0xFFFFFFFF, and both outputs are low.
- R2: The register offsets are: load 0x000, counter 0x004, control 0x008, interrupt clear 0x00C, raw status 0x010, masked status 0x014, gate 0xC00. The counter register is read-only, and interrupt clear reads as 0. A read presented at a clock edge returns its data on bus_rdata from that edge until the next edge. bus_rdata is 0 when no read was presented.
- R3: While control bit 0 is set, the counter falls by one per clock. While it is clear, the counter holds its value.
- R4: When an enabled count is at zero and no interrupt is pending, the next edge sets raw status bit 0 and reloads the counter from the load register.
- R5: When an enabled count is at zero while the interrupt is pending and control bit 1 is set, the reset output rises. It stays high, whatever the bus does, until the block's reset input is applied.
- R6: The same second expiry with control bit 1 clear reloads the counter and leaves the reset output low.
- R7: A write of any value to interrupt clear clears raw status and reloads the counter from the load register.
- R8: Masked status bit 0 equals raw status AND control bit 0. The interrupt output follows the masked status bit.
- R9: Writing 0x1ACCE551 to the gate opens it. Any other value closes it. The gate reads 1 when closed and 0 when open. While it is closed, writes to the load, control and interrupt-clear registers have no effect.
- R10: A write to the load register reloads the counter with the written value at once. A written value of 0 is stored as 1.
- R11: Reads from unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, the masked status bit |
| wdt_rst_o | output | 1 | Sticky system reset request |

## Verification
A register write changes state at the clock edge where it is presented. Read data for an access presented in one cycle is due one edge later. A counter, status or interrupt change caused by an expiry or a write shows one edge after its cause, and the reset request likewise rises one edge after the second expiry. The bench drives inputs on falling edges and compares every output on every falling edge against a model that it advances on each rising edge. The directed checks rely only on differences whose cycle distance is fixed by the bus tasks, such as two counter reads taken exactly two edges apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFF_LOAD  = 32'h000;
  localparam int unsigned OFF_COUNT = 32'h004;
  localparam int unsigned OFF_CTRL  = 32'h008;
  localparam int unsigned OFF_CLEAR = 32'h00C;
  localparam int unsigned OFF_RAW   = 32'h010;
  localparam int unsigned OFF_MASK  = 32'h014;
  localparam int unsigned OFF_GATE  = 32'hC00;
  localparam logic [31:0] GATE_KEY  = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output wdog_ctrl_t        ctrl_q,
  output logic              locked_q,
  output logic              ld_stb,
  output logic              clr_stb,
  output logic [DATA_W-1:0] ld_val
);
  localparam logic [DATA_W-1:0] LOAD_RST = '1;
  localparam logic [DATA_W-1:0] LOAD_MIN = DATA_W'(1);

  logic wr_go, hit_load, hit_ctrl, hit_clear, hit_gate;

  assign wr_go     = sel && wr;
  assign hit_load  = addr == ADDR_W'(OFF_LOAD);
  assign hit_ctrl  = addr == ADDR_W'(OFF_CTRL);
  assign hit_clear = addr == ADDR_W'(OFF_CLEAR);
  assign hit_gate  = addr == ADDR_W'(OFF_GATE);

  assign ld_stb  = wr_go && !locked_q && hit_load;
  assign clr_stb = wr_go && !locked_q && hit_clear;
  assign ld_val  = (wdata == '0) ? LOAD_MIN : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= LOAD_RST;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_go && hit_gate) locked_q <= (wdata != DATA_W'(GATE_KEY));
      if (ld_stb) load_q <= ld_val;
      if (wr_go && !locked_q && hit_ctrl) begin
        ctrl_q.cnt_en <= wdata[0];
        ctrl_q.rst_en <= wdata[1];
      end
    end
  end

  // R9: a closed gate keeps load and control unchanged
  assert_gate_holds_R9: assert property (@(posedge clk) disable iff (rst)
    locked_q && sel && wr && !hit_gate |=> $stable(load_q) && $stable(ctrl_q));

  // R10: a stored load is never zero
  assert_load_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> load_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              rst_en,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              raw_q,
  output logic              wrst_q
);
  localparam logic [DATA_W-1:0] CNT_RST = '1;

  logic expire;
  assign expire = cnt_en && !ld_stb && !clr_stb && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_RST;
      raw_q  <= 1'b0;
      wrst_q <= 1'b0;
    end else begin
      if (ld_stb)       cnt_q <= ld_val;
      else if (clr_stb) cnt_q <= load_q;
      else if (cnt_en)  cnt_q <= (cnt_q == '0) ? load_q : cnt_q - 1'b1;

      if (clr_stb)     raw_q <= 1'b0;
      else if (expire) raw_q <= 1'b1;

      if (expire && raw_q && rst_en) wrst_q <= 1'b1;
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_en && !ld_stb && !clr_stb && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cnt_en && !ld_stb && !clr_stb |=> $stable(cnt_q));

  assert_first_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    expire && !raw_q |=> raw_q && cnt_q == $past(load_q));

  assert_reset_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    wrst_q |=> wrst_q);

  assert_no_reset_R6: assert property (@(posedge clk) disable iff (rst)
    expire && !rst_en && !wrst_q |=> !wrst_q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> !raw_q && cnt_q == $past(load_q));

  assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> cnt_q == $past(ld_val));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] cnt_q,
  input  wdog_ctrl_t        ctrl_q,
  input  logic              raw_q,
  input  logic              locked_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (sel && !wr) begin
      if (addr == ADDR_W'(OFF_LOAD))  rd_next = load_q;
      if (addr == ADDR_W'(OFF_COUNT)) rd_next = cnt_q;
      if (addr == ADDR_W'(OFF_CTRL))  rd_next = DATA_W'({ctrl_q.rst_en, ctrl_q.cnt_en});
      if (addr == ADDR_W'(OFF_RAW))   rd_next = DATA_W'(raw_q);
      if (addr == ADDR_W'(OFF_MASK))  rd_next = DATA_W'(raw_q & ctrl_q.cnt_en);
      if (addr == ADDR_W'(OFF_GATE))  rd_next = DATA_W'(locked_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  // R2: an idle bus cycle yields zero read data
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |=> rdata_q == '0);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic [DATA_W-1:0] load_q, cnt_q, ld_val;
  wdog_ctrl_t        ctrl_q;
  logic              locked_q, ld_stb, clr_stb, raw_q, wrst_q;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .load_q(load_q), .ctrl_q(ctrl_q), .locked_q(locked_q),
    .ld_stb(ld_stb), .clr_stb(clr_stb), .ld_val(ld_val)
  );

  wdog_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .cnt_en(ctrl_q.cnt_en), .rst_en(ctrl_q.rst_en),
    .ld_stb(ld_stb), .ld_val(ld_val), .clr_stb(clr_stb), .load_q(load_q),
    .cnt_q(cnt_q), .raw_q(raw_q), .wrst_q(wrst_q)
  );

  wdog_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .load_q(load_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .raw_q(raw_q),
    .locked_q(locked_q), .rdata_q(bus_rdata)
  );

  assign irq_o     = raw_q & ctrl_q.cnt_en;
  assign wdt_rst_o = wrst_q;
endmodule

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;
  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdt_rst_o;
  int tests = 0, fails = 0, cyc = 0;
  bit chk_on = 0, done = 0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  wdog_twostage u0 (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o));

  always #5 clk = ~clk;

  // reference model advanced on each rising edge
  logic [31:0] m_cnt, m_load, m_rdata;
  logic [1:0]  m_ctrl;
  logic        m_raw, m_wrst, m_lock;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return {30'b0, m_ctrl};
      12'h010: return {31'b0, m_raw};
      12'h014: return {31'b0, m_raw & m_ctrl[0]};
      12'hC00: return {31'b0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '1; m_load <= '1; m_ctrl <= 0; m_raw <= 0; m_wrst <= 0;
      m_lock <= 0; m_rdata <= 0;
    end else begin
      logic wo, ld, clr, ex;
      logic [31:0] lv;
      wo  = bus_sel && bus_wr;
      ld  = wo && !m_lock && bus_addr == 12'h000;
      clr = wo && !m_lock && bus_addr == 12'h00C;
      lv  = (bus_wdata == 0) ? 32'd1 : bus_wdata;
      ex  = m_ctrl[0] && !ld && !clr && m_cnt == 0;
      m_rdata <= (bus_sel && !bus_wr) ? m_read(bus_addr) : 32'h0;
      if (wo && bus_addr == 12'hC00) m_lock <= (bus_wdata != KEY);
      if (ld) m_load <= lv;
      if (wo && !m_lock && bus_addr == 12'h008) m_ctrl <= bus_wdata[1:0];
      if (ld) m_cnt <= lv;
      else if (clr) m_cnt <= m_load;
      else if (m_ctrl[0]) m_cnt <= (m_cnt == 0) ? m_load : m_cnt - 1;
      if (clr) m_raw <= 0; else if (ex) m_raw <= 1;
      if (ex && m_raw && m_ctrl[1]) m_wrst <= 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !rst) begin
    chk("R2 rdata", bus_rdata, m_rdata);
    chk("R8 irq", {31'b0, irq_o}, {31'b0, m_raw & m_ctrl[0]});
    chk("R5 wdt_rst", {31'b0, wdt_rst_o}, {31'b0, m_wrst});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bus_sel = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, v1, v2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0; chk_on = 1;
    // R1 reset state
    rd(12'hC00, d); chk("R1 gate", d, 0);
    rd(12'h000, d); chk("R1 load", d, 32'hFFFFFFFF);
    rd(12'h008, d); chk("R1 ctrl", d, 0);
    rd(12'h004, d); chk("R1 count", d, 32'hFFFFFFFF);
    chk("R1 outputs", {30'b0, irq_o, wdt_rst_o}, 0);
    // R10 zero load, reload
    wr(12'h000, 0); rd(12'h000, d); chk("R10 zero->1", d, 1);
    wr(12'h000, 5); rd(12'h004, d); chk("R10 reload", d, 5);
    // R2 count read-only
    wr(12'h004, 32'h1234); rd(12'h004, d); chk("R2 count ro", d, 5);
    rd(12'h00C, d); chk("R2 clear reads 0", d, 0);
    // R3 hold then step
    idle(5); rd(12'h004, d); chk("R3 hold", d, 5);
    wr(12'h000, 100); wr(12'h008, 1);
    rd(12'h004, v1); rd(12'h004, v2); chk("R3 step", v1 - v2, 2);
    // R4 first expiry, R6 no reset
    wr(12'h000, 5); wr(12'h00C, 0); idle(9);
    rd(12'h010, d); chk("R4 raw", d, 1);
    rd(12'h014, d); chk("R8 masked", d, 1);
    idle(20); chk("R6 no reset", {31'b0, wdt_rst_o}, 0);
    // R8 masking
    wr(12'h008, 0); rd(12'h014, d); chk("R8 masked off", d, 0);
    rd(12'h010, d); chk("R8 raw kept", d, 1);
    chk("R8 irq low", {31'b0, irq_o}, 0);
    // R7 clear
    wr(12'h00C, 32'hDEAD); rd(12'h010, d); chk("R7 raw cleared", d, 0);
    rd(12'h004, d); chk("R7 reload", d, 5);
    // R5 second expiry
    wr(12'h008, 3); idle(20); chk("R5 reset high", {31'b0, wdt_rst_o}, 1);
    wr(12'h00C, 0); wr(12'h008, 0); idle(3);
    chk("R5 sticky", {31'b0, wdt_rst_o}, 1);
    do_reset(); chk("R5 cleared by reset", {31'b0, wdt_rst_o}, 0);
    // R9 gate
    wr(12'hC00, 1); rd(12'hC00, d); chk("R9 gate closed", d, 1);
    wr(12'h000, 9); rd(12'h000, d); chk("R9 load blocked", d, 32'hFFFFFFFF);
    wr(12'h008, 1); rd(12'h008, d); chk("R9 ctrl blocked", d, 0);
    wr(12'hC00, KEY); rd(12'hC00, d); chk("R9 gate open", d, 0);
    wr(12'h000, 9); rd(12'h000, d); chk("R9 load open", d, 9);
    // R11 unmapped
    wr(12'h020, 32'hFFFF); rd(12'h020, d); chk("R11 unmapped read", d, 0);
    rd(12'h000, d); chk("R11 load kept", d, 9);
    rd(12'h008, d); chk("R11 ctrl kept", d, 0);
    // random phase, compared against model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; rst = 0;
      r = $urandom % 20;
      if (m_wrst && ($urandom % 8 == 0)) rst = 1;
      else if (r == 8 || r == 9) begin
        logic [11:0] al [8] = '{12'h000, 12'h004, 12'h008, 12'h00C,
                                12'h010, 12'h014, 12'hC00, 12'h040};
        bus_sel = 1; bus_addr = al[$urandom % 8];
      end else if (r == 10) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h000; bus_wdata = $urandom % 24;
      end else if (r == 11 || r == 12) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h00C; bus_wdata = $urandom;
      end else if (r == 13) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h008; bus_wdata = $urandom % 4;
      end else if (r == 14) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'hC00; bus_wdata = KEY;
      end else if (r == 15 && ($urandom % 3 == 0)) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'hC00; bus_wdata = 1;
      end else if (r == 16) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h03C; bus_wdata = $urandom;
      end else if (r == 17) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h004; bus_wdata = $urandom;
      end
    end
    @(negedge clk); bus_sel = 0; rst = 0;
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule